// File: doc/BRIEF.md
# Status Monitor Interrupt Unit

This block watches twelve configuration status lines coming from a programmable fabric and turns them into one interrupt. The lines are status, configuration-done, initialisation-done, CRC error, an alternate configuration-done, three partial-reconfiguration flags (ready, error, done), three pin levels and power-good. Each line passes through a two-flop synchroniser. Software can then choose, line by line, whether the line raises a condition while it sits at its active level or latches a condition when it moves to its active level. Latched conditions stay pending until software writes a one to the end-of-interrupt register.

Software programs four per-line control registers through a simple write port:

- enable
- mask
- trigger type
- polarity

It reads back the following through a combinational read port:

- the same four control registers
- the raw pending vector
- the masked pending vector
- the live synchronised line levels

All registers use one bit map: bit 0 status, bit 1 configuration-done, bit 2 initialisation-done, bit 3 CRC error, bit 4 alternate configuration-done, bits 5 to 7 partial-reconfiguration ready/error/done, bits 8 to 10 pin levels, bit 11 power-good.

Each line owns a two-state tracker. In state IDLE nothing is latched. The tracker moves IDLE to PEND when its line is edge-type and the selected edge is seen. It moves PEND to IDLE when an end-of-interrupt write sets its bit and no new edge arrives in that same cycle. It also moves PEND to IDLE at once whenever its line is switched to level type. Neither the enable nor the mask affects the tracker; they act only on the masked view.

Top module: `smi_irq_unit`

## Requirements
- R1: After reset, the control registers, the masked status and the external port all read zero, and `irq_o` is low. With all lines low, raw status reads 0xFFF, because the reset polarity of 0 makes every level-type line active when low.
- R2: A write sets a control register, and that register reads back the written 12 bits; bits 31:12 of every read are zero. The control registers are enable at 0x830, mask at 0x834, trigger type at 0x838 and polarity at 0x83C.
- R3: Address 0x850 returns the synchronised live levels of the twelve lines.
- R4: For a line whose type bit is 0 (level), its raw status bit at 0x844 follows the line: it is 1 while the line is high if the polarity bit is 1, and 1 while the line is low if the polarity bit is 0.
- R5: For a line whose type bit is 1 (edge), a rising edge sets its raw bit if the polarity bit is 1, and a falling edge sets it if the polarity bit is 0. The bit stays set after the line returns to its previous level; the opposite edge does not set it.
- R6: Writing a 1 to a bit of the end-of-interrupt register at 0x84C clears that line's latched condition; a 0 bit leaves the line untouched. End-of-interrupt has no effect on level-type lines, and reading 0x84C returns zero.
- R7: Masked status at 0x840 equals raw AND enable AND NOT mask; a mask bit of 1 hides the line.
- R8: `irq_o` is the OR of the masked status bits. It is low from the first cycle after a write of zero to the enable register.
- R9: If the selected edge arrives in the same cycle as an end-of-interrupt write to that line, the condition stays pending.
- R10: Switching a line to level type discards its latched condition, so returning it to edge type shows no pending bit until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_i | input | 12 | Asynchronous status lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write byte address |
| wr_data_i | input | 12 | Write data, one bit per line |
| rd_addr_i | input | 12 | Read byte address |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: twelve lines and two synchroniser stages. With this depth, an input change reaches the live value two edges later and reaches an edge latch three edges later. That fixed timing lets the bench place an end-of-interrupt write in exactly the cycle the latch sets, which is the collision case of R9. The twelve lines also give room to give one group of lines rising-edge polarity and another group falling-edge polarity, and to drive both groups in a single pattern.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h830;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h834;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 12'h838;
    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h83C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT  = 12'h840;
    localparam logic [ADDR_W-1:0] OFS_RSTAT  = 12'h844;
    localparam logic [ADDR_W-1:0] OFS_EOI    = 12'h84C;
    localparam logic [ADDR_W-1:0] OFS_PORT   = 12'h850;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;
endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/smi_chan.sv
module smi_chan
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic edge_type_i,
    input  logic pol_i,
    input  logic eoi_i,
    output logic raw_o
);
    chan_state_e state_q, state_d;
    logic        prev_q;
    logic        edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= live_i;
    end

    assign edge_hit = edge_type_i &
                      (pol_i ? (live_i & ~prev_q) : (~live_i & prev_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (edge_hit) state_d = CH_PEND;
            CH_PEND: begin
                if (!edge_type_i)            state_d = CH_IDLE;
                else if (eoi_i && !edge_hit) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        if (edge_type_i) raw_o = (state_q == CH_PEND);
        else             raw_o = pol_i ? live_i : ~live_i;
    end

    // R5
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_type_i && pol_i && $rose(live_i)) |=> (state_q == CH_PEND));

    // R9
    eoi_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && eoi_i) |=> (state_q == CH_PEND));

    // R10
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_type_i) |=> (state_q == CH_IDLE));
endmodule

// File: rtl/smi_regs.sv
module smi_regs
    import smi_pkg::*;
#(
    parameter int N_MON  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [N_MON-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [N_MON-1:0]  raw_i,
    input  logic [N_MON-1:0]  masked_i,
    input  logic [N_MON-1:0]  live_i,
    output logic [N_MON-1:0]  en_o,
    output logic [N_MON-1:0]  msk_o,
    output logic [N_MON-1:0]  typ_o,
    output logic [N_MON-1:0]  pol_o,
    output logic [N_MON-1:0]  eoi_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD = DATA_W - N_MON;

    logic [N_MON-1:0] en_q, msk_q, typ_q, pol_q;
    logic [N_MON-1:0] rd_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            msk_q <= '0;
            typ_q <= '0;
            pol_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == OFS_ENABLE) en_q  <= wr_data_i;
            if (wr_addr_i == OFS_MASK)   msk_q <= wr_data_i;
            if (wr_addr_i == OFS_TYPE)   typ_q <= wr_data_i;
            if (wr_addr_i == OFS_POL)    pol_q <= wr_data_i;
        end
    end

    assign eoi_o = (wr_en_i && wr_addr_i == OFS_EOI) ? wr_data_i : '0;

    always_comb begin
        case (rd_addr_i)
            OFS_ENABLE: rd_sel = en_q;
            OFS_MASK:   rd_sel = msk_q;
            OFS_TYPE:   rd_sel = typ_q;
            OFS_POL:    rd_sel = pol_q;
            OFS_MSTAT:  rd_sel = masked_i;
            OFS_RSTAT:  rd_sel = raw_i;
            OFS_PORT:   rd_sel = live_i;
            default:    rd_sel = '0;
        endcase
    end

    assign rd_data_o = {{PAD{1'b0}}, rd_sel};
    assign en_o  = en_q;
    assign msk_o = msk_q;
    assign typ_o = typ_q;
    assign pol_o = pol_q;

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == OFS_ENABLE) |=> (en_o == $past(wr_data_i)));
endmodule

// File: rtl/smi_irq_unit.sv
module smi_irq_unit
    import smi_pkg::*;
#(
    parameter int N_MON       = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MON-1:0]  mon_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [N_MON-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [N_MON-1:0] live, raw, masked;
    logic [N_MON-1:0] en, msk, typ, pol, eoi;

    smi_sync #(.WIDTH(N_MON), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mon_i),
        .sync_o  (live)
    );

    for (genvar i = 0; i < N_MON; i++) begin : g_chan
        smi_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .live_i      (live[i]),
            .edge_type_i (typ[i]),
            .pol_i       (pol[i]),
            .eoi_i       (eoi[i]),
            .raw_o       (raw[i])
        );
    end

    assign masked = raw & en & ~msk;
    assign irq_o  = |masked;

    smi_regs #(.N_MON(N_MON), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .raw_i     (raw),
        .masked_i  (masked),
        .live_i    (live),
        .en_o      (en),
        .msk_o     (msk),
        .typ_o     (typ),
        .pol_o     (pol),
        .eoi_o     (eoi),
        .rd_data_o (rd_data_o)
    );

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);

    // R7
    masked_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked & (msk | ~en)) == '0);
endmodule

// File: tb/smi_irq_unit_bench.sv
module smi_irq_unit_bench;
    localparam int N = 12;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        logic [31:0] tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] mon = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    smi_irq_unit u_smi_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_i     (mon),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic [31:0] lvl(input logic [N-1:0] m, input logic [N-1:0] p);
        return {20'h0, ~(m ^ p)};
    endfunction

    task automatic push_rd(input logic [11:0] a, input logic [31:0] e, input logic [31:0] t);
        item_t it;
        it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    task automatic push_irq(input logic e, input logic [31:0] t);
        item_t it;
        it.is_irq = 1'b1; it.addr = '0; it.exp = {31'h0, e}; it.tag = t;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mon(input logic [N-1:0] v);
        @(negedge clk);
        mon = v;
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                rd_addr = it.addr;
                #1;
                got = it.is_irq ? {31'h0, irq} : rd_data;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: addr %h got %h expected %h", it.tag, it.addr, got, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        push_rd(12'h830, 0, "R1"); push_rd(12'h834, 0, "R1");
        push_rd(12'h838, 0, "R1"); push_rd(12'h83C, 0, "R1");
        push_rd(12'h840, 0, "R1"); push_rd(12'h850, 0, "R1");
        push_rd(12'h844, 32'hFFF, "R1"); push_irq(1'b0, "R1");
        drain();

        // R2 register write/readback
        wr(12'h830, 12'hABC); wr(12'h834, 12'h555);
        wr(12'h838, 12'h0F0); wr(12'h83C, 12'hF0F);
        push_rd(12'h830, 32'hABC, "R2"); push_rd(12'h834, 32'h555, "R2");
        push_rd(12'h838, 32'h0F0, "R2"); push_rd(12'h83C, 32'hF0F, "R2");
        drain();
        wr(12'h830, 0); wr(12'h834, 0); wr(12'h838, 0); wr(12'h83C, 0);

        // R3 external port
        set_mon(12'h5A3);
        push_rd(12'h850, 32'h5A3, "R3");
        drain();

        // R4 level type, several polarity patterns
        wr(12'h83C, 12'hFFF);
        push_rd(12'h844, lvl(12'h5A3, 12'hFFF), "R4");
        drain();
        wr(12'h83C, 12'h000);
        push_rd(12'h844, lvl(12'h5A3, 12'h000), "R4");
        drain();
        wr(12'h83C, 12'h0FF);
        push_rd(12'h844, lvl(12'h5A3, 12'h0FF), "R4");
        drain();

        // R5 edge type, rising on bits 3:0, falling on the rest
        set_mon(12'h000);
        wr(12'h83C, 12'h00F); wr(12'h838, 12'hFFF); wr(12'h84C, 12'hFFF);
        push_rd(12'h844, 0, "R5");
        drain();
        set_mon(12'h0FF);
        push_rd(12'h844, 32'h00F, "R5");
        drain();
        set_mon(12'h000);
        push_rd(12'h844, 32'h0FF, "R5");
        drain();

        // R6 end-of-interrupt clears selected bits only
        wr(12'h84C, 12'h003);
        push_rd(12'h844, 32'h0FC, "R6");
        push_rd(12'h84C, 0, "R6");
        drain();

        // R7 masked status
        wr(12'h830, 12'h0F0); wr(12'h834, 12'h030);
        push_rd(12'h840, 32'h0C0, "R7");
        push_irq(1'b1, "R8");
        drain();

        // R8 interrupt follows masked status and enable
        wr(12'h834, 12'h0F0);
        push_rd(12'h840, 0, "R7"); push_irq(1'b0, "R8");
        drain();
        wr(12'h834, 12'h000);
        push_irq(1'b1, "R8");
        drain();
        wr(12'h830, 12'h000);
        #1;
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R8: irq got %b expected 0 right after enable cleared", irq);
        end

        // R9 edge colliding with end-of-interrupt stays pending
        wr(12'h84C, 12'hFFF);
        @(negedge clk);
        mon = 12'h001;
        @(negedge clk);
        wr(12'h84C, 12'h001);
        repeat (2) @(negedge clk);
        push_rd(12'h844, 32'h001, "R9");
        drain();
        wr(12'h84C, 12'h001);
        push_rd(12'h844, 0, "R6");
        drain();

        // R10 switching to level discards the latch
        set_mon(12'h000);
        set_mon(12'h001);
        push_rd(12'h844, 32'h001, "R10");
        drain();
        wr(12'h838, 12'h000);
        push_rd(12'h844, lvl(12'h001, 12'h00F), "R10");
        drain();
        wr(12'h84C, 12'hFFF);
        push_rd(12'h844, lvl(12'h001, 12'h00F), "R6");
        drain();
        wr(12'h838, 12'hFFF);
        push_rd(12'h844, 0, "R10");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule